// File: doc/BRIEF.md
# Ready-Pulse Serial Result Reader

This block is the host end of a single-wire result path in which one converter pin carries both a "result ready" marker and the serial data that follows it. With no chip select, the reader tracks the shared pin through its synchronizer. It waits for the pin to pulse low and come back high. It then waits a fixed settle count and drives a burst of exactly 24 serial clocks. It captures one bit per clock, most significant bit first, and hands the assembled word to the fabric together with a one-cycle valid strobe.

The settle delay is a fixed cycle count. The end of the ready pulse is never inferred from a later low level, because a negative result has its top bit set and leaves the pin high after the pulse.

The reader can also start a synchronization on request. It parks the serial clock high and counts ready frames. It then releases the clock with a falling edge, and the next ready pulse is read as a normal frame. A frame is counted either when the pin is seen to fall, or when a full frame period passes with no fall. The second case covers a converter that stops pulsing once it sees the clock held high.

Top module: `pulse_frame_reader`

## Requirements
- R1: Outside a read or a synchronization, `sclk_o` is low and `busy_o` is low; after reset `valid_o` is low and `word_o` is zero.
- R2: A read starts only after the synchronized pin has been seen high, then low, then high again; a pin held high, or held low without returning high, produces no serial clock edge.
- R3: The first rising edge of `sclk_o` comes no earlier than `SETTLE_CYC` and no later than `SETTLE_CYC + 5` system clocks after the pin returns high.
- R4: Each read produces exactly 24 rising edges on `sclk_o`, each high and low phase lasting `HALF_CYC` system clocks.
- R5: A bit is captured during each high phase of `sclk_o` (the device moves data on falling edges). The first captured bit becomes bit 23 of `word_o` and the last becomes bit 0, and a word whose bit 23 is 1 is read correctly.
- R6: `valid_o` is high for exactly one system clock, in the cycle in which `sclk_o` falls for the 24th time; `word_o` changes only in that cycle and otherwise holds the last result.
- R7: `busy_o` is high from the start of the settle wait until the cycle of `valid_o`, and during a synchronization.
- R8: A one-cycle `sync_req_i` while not busy holds `sclk_o` high until the frame count reaches `sync_frames_i`, raised to a minimum of 5. Each falling edge of the synchronized pin counts one frame. `sclk_o` then falls and `busy_o` drops.
- R9: During a synchronization, `FRAME_CYC` system clocks with no pin falling edge also count as one frame.
- R10: After a synchronization ends, the next ready pulse is read as a normal frame with a valid word.
- R11: `sync_req_i` is ignored while a read is in progress: the read completes normally and `sclk_o` stays low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Shared ready/data pin from the converter |
| sync_req_i | input | 1 | One-cycle request to start a synchronization |
| sync_frames_i | input | 8 | Synchronization length in frames (values below 5 are treated as 5) |
| sclk_o | output | 1 | Serial clock to the converter |
| word_o | output | 24 | Last assembled result |
| valid_o | output | 1 | One-cycle strobe marking a new `word_o` |
| busy_o | output | 1 | Settle wait, read or synchronization in progress |

## Verification
The assertions take for granted that `sync_req_i` is a single-cycle pulse and that the shared pin holds each data bit for a whole serial-clock high phase. They also assume the pin does not form a second ready pulse while a read is under way. The stimulus keeps to these assumptions. Its converter model changes the pin only just after a falling edge of `sclk_o`. It issues synchronization requests as one-cycle pulses, and it returns the pin high only after the 24th bit has been taken. Ready pulses during a synchronization are kept shorter than `FRAME_CYC`, so the pulse-counting and timeout cases can each be exercised on their own.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE_HI,
    ST_WAIT_LO,
    ST_WAIT_RISE,
    ST_SETTLE,
    ST_READ,
    ST_SYNC
  } rd_state_e;
endpackage

// File: rtl/pfr_pin_sync.sv
module pfr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // pin idles high when the converter is in ready mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign pin_s_o = chain_q[STAGES-1];
  assign fall_o  = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pfr_shifter.sv
module pfr_shifter #(
  parameter int DATA_W   = 24,
  parameter int HALF_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pin_s_i,
  output logic              sclk_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int PH_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = $clog2(DATA_W);

  logic              active_q;
  logic [PH_W-1:0]   ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;
  logic              ph_end;

  assign ph_end  = (ph_q == PH_W'(HALF_CYC - 1));
  assign sh_next = {sh_q[DATA_W-2:0], pin_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      sclk_o   <= 1'b0;
      done_o   <= 1'b0;
      word_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        ph_q     <= '0;
        bit_q    <= '0;
        sclk_o   <= 1'b1;
      end else if (active_q) begin
        if (!ph_end) begin
          ph_q <= ph_q + 1'b1;
        end else begin
          ph_q <= '0;
          if (sclk_o) begin
            // capture at the end of the high phase, then drop the clock
            sclk_o <= 1'b0;
            sh_q   <= sh_next;
            if (bit_q == BIT_W'(DATA_W - 1)) begin
              active_q <= 1'b0;
              done_o   <= 1'b1;
              word_o   <= sh_next;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            sclk_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pfr_sync_ctrl.sv
module pfr_sync_ctrl #(
  parameter int FRAME_W    = 8,
  parameter int FRAME_CYC  = 64,
  parameter int MIN_FRAMES = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               fall_i,
  input  logic [FRAME_W-1:0] frames_i,
  output logic               done_o
);
  localparam int TMO_W = $clog2(FRAME_CYC);

  logic [FRAME_W-1:0] cnt_q;
  logic [TMO_W-1:0]   tmo_q;
  logic [FRAME_W-1:0] target;
  logic               tick;

  assign target = (frames_i < FRAME_W'(MIN_FRAMES)) ? FRAME_W'(MIN_FRAMES) : frames_i;
  // a missing pulse still ends a frame: the converter stops pulsing once parked
  assign tick   = fall_i || (tmo_q == TMO_W'(FRAME_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      tmo_q <= '0;
    end else if (tick) begin
      tmo_q <= '0;
      if (cnt_q != target) cnt_q <= cnt_q + 1'b1;
    end else begin
      tmo_q <= tmo_q + 1'b1;
    end
  end

  assign done_o = en_i && (cnt_q == target);
endmodule

// File: rtl/pulse_frame_reader.sv
module pulse_frame_reader
  import pfr_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int HALF_CYC   = 4,
  parameter int SETTLE_CYC = 12,
  parameter int FRAME_W    = 8,
  parameter int FRAME_CYC  = 64,
  parameter int MIN_FRAMES = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_i,
  input  logic               sync_req_i,
  input  logic [FRAME_W-1:0] sync_frames_i,
  output logic               sclk_o,
  output logic [DATA_W-1:0]  word_o,
  output logic               valid_o,
  output logic               busy_o
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  rd_state_e       state_q;
  logic [SET_W-1:0] set_q;
  logic            pin_s;
  logic            pin_fall;
  logic            start;
  logic            sh_sclk;
  logic            sh_done;
  logic            sync_done;
  logic            in_sync;
  logic            accept_sync;

  pfr_pin_sync #(.STAGES(2)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .pin_s_o(pin_s),
    .fall_o (pin_fall)
  );

  pfr_shifter #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .pin_s_i(pin_s),
    .sclk_o (sh_sclk),
    .done_o (sh_done),
    .word_o (word_o)
  );

  pfr_sync_ctrl #(.FRAME_W(FRAME_W), .FRAME_CYC(FRAME_CYC), .MIN_FRAMES(MIN_FRAMES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (in_sync),
    .fall_i  (pin_fall),
    .frames_i(sync_frames_i),
    .done_o  (sync_done)
  );

  assign in_sync     = (state_q == ST_SYNC);
  assign start       = (state_q == ST_SETTLE) && (set_q == SET_W'(SETTLE_CYC - 1));
  assign accept_sync = sync_req_i &&
                       (state_q inside {ST_IDLE_HI, ST_WAIT_LO, ST_WAIT_RISE});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE_HI;
      set_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE_HI:   if (accept_sync) state_q <= ST_SYNC;
                      else if (pin_s) state_q <= ST_WAIT_LO;
        ST_WAIT_LO:   if (accept_sync) state_q <= ST_SYNC;
                      else if (!pin_s) state_q <= ST_WAIT_RISE;
        ST_WAIT_RISE: if (accept_sync) state_q <= ST_SYNC;
                      else if (pin_s) begin
                        state_q <= ST_SETTLE;
                        set_q   <= '0;
                      end
        // pin level is ignored here: a set MSB keeps it high after the pulse
        ST_SETTLE:    if (start) state_q <= ST_READ;
                      else set_q <= set_q + 1'b1;
        ST_READ:      if (sh_done) state_q <= ST_IDLE_HI;
        ST_SYNC:      if (sync_done) state_q <= ST_IDLE_HI;
        default:      state_q <= ST_IDLE_HI;
      endcase
    end
  end

  assign sclk_o  = sh_sclk | in_sync;
  assign valid_o = sh_done;
  assign busy_o  = state_q inside {ST_SETTLE, ST_READ, ST_SYNC};
endmodule

// File: rtl/pulse_frame_reader_chk.sv
module pulse_frame_reader_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_i,
  input logic              valid_i,
  input logic              busy_i,
  input logic [DATA_W-1:0] word_i,
  input logic              in_sync_i
);
  logic [5:0] rise_cnt_q;
  logic       sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt_q <= '0;
      sclk_q     <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      if (valid_i || in_sync_i) rise_cnt_q <= '0;
      else if (sclk_i && !sclk_q) rise_cnt_q <= rise_cnt_q + 1'b1;
    end
  end

  p_sclk_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sclk_i);

  p_bit_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (rise_cnt_q == 6'(DATA_W)));

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_word_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_i) |-> valid_i);

  p_valid_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> busy_i && !in_sync_i);

  p_sync_entry_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_sync_i) |-> !$past(busy_i));
endmodule

bind pulse_frame_reader pulse_frame_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_i   (sclk_o),
  .valid_i  (valid_o),
  .busy_i   (busy_o),
  .word_i   (word_o),
  .in_sync_i(in_sync)
);

// File: tb/pulse_frame_reader_bench.sv
`timescale 1ns/1ps
module pulse_frame_reader_bench;
  localparam int SETTLE = 12;
  localparam int FRCYC  = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b1;
  logic        sync_req_i = 1'b0;
  logic [7:0]  sync_frames_i = 8'd6;
  logic        sclk_o;
  logic [23:0] word_o;
  logic        valid_o;
  logic        busy_o;

  int errors = 0;
  int checks = 0;
  int rises  = 0;
  logic [23:0] last_word = '0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge sclk_o) rises++;

  pulse_frame_reader u_pulse_frame_reader (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .sync_req_i(sync_req_i),
    .sync_frames_i(sync_frames_i), .sclk_o(sclk_o), .word_o(word_o),
    .valid_o(valid_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic ready_pulse(input int low_len, input int high_len);
    pin_i = 1'b0;
    cyc(low_len);
    pin_i = 1'b1;
    cyc(high_len);
  endtask

  // one converter frame: ready pulse, then bits moved after each falling sclk
  task automatic read_frame(input logic [23:0] w, input int low_len, input bit inject_sync);
    int n;
    rises = 0;
    pin_i = 1'b0;
    cyc(low_len);
    chk(rises == 0 && !busy_o, "R2", "no clock while pin low", rises, 0);
    pin_i = 1'b1;
    n = 0;
    while (!sclk_o && n < 100) begin
      cyc(1);
      n++;
      if (n == 3) pin_i = w[23];
    end
    chk(n >= SETTLE && n <= SETTLE + 5, "R3", "settle to first sclk", n, SETTLE);
    chk(busy_o, "R7", "busy during read", busy_o, 1);
    for (int i = 22; i >= 0; i--) begin
      @(negedge sclk_o);
      #1;
      pin_i = w[i];
      if (inject_sync && i == 12) begin
        @(posedge clk_i); #1; sync_req_i = 1'b1;
        @(posedge clk_i); #1; sync_req_i = 1'b0;
      end
    end
    @(negedge sclk_o);
    #1;
    chk(valid_o, "R6", "valid at last falling sclk", valid_o, 1);
    chk(word_o == w, "R5", "assembled word", word_o, w);
    chk(rises == 24, "R4", "sclk rising edges", rises, 24);
    cyc(1);
    chk(!valid_o, "R6", "valid one cycle wide", valid_o, 0);
    last_word = w;
    cyc(4);
    pin_i = 1'b1;
    cyc(20);
    chk(!busy_o && !sclk_o && rises == 24, "R1", "idle after read", {busy_o, sclk_o}, 0);
  endtask

  task automatic t_reset;
    chk(!sclk_o && !valid_o && !busy_o && word_o == 0, "R1", "reset state",
        {sclk_o, valid_o, busy_o, word_o}, 0);
  endtask

  task automatic t_no_pulse;
    rises = 0;
    cyc(100);
    chk(rises == 0 && !busy_o, "R2", "pin held high gives no clocks", rises, 0);
  endtask

  task automatic t_reads;
    read_frame(24'hA5C3F0, 4, 1'b0);
    read_frame(24'h800001, 4, 1'b0);  // negative: pin stays high after pulse
    read_frame(24'h000000, 4, 1'b0);
    read_frame(24'hFFFFFF, 40, 1'b0); // long low before return high
    read_frame(24'h5A5A5A, 4, 1'b0);
  endtask

  task automatic t_sync_during_read;
    read_frame(24'h123456, 4, 1'b1);
    rises = 0;
    cyc(40);
    chk(rises == 0 && !sclk_o && !busy_o, "R11", "sync request ignored in read",
        {rises[7:0], sclk_o}, 0);
  endtask

  task automatic send_sync_req(input logic [7:0] f);
    sync_frames_i = f;
    sync_req_i = 1'b1;
    cyc(1);
    sync_req_i = 1'b0;
    cyc(4);
  endtask

  task automatic t_sync_pulses;
    send_sync_req(8'd6);
    chk(sclk_o && busy_o, "R8", "sclk parked high", {sclk_o, busy_o}, 3);
    for (int k = 0; k < 5; k++) ready_pulse(4, 16);
    chk(sclk_o, "R8", "still high after 5 of 6 frames", sclk_o, 1);
    ready_pulse(4, 16);
    chk(!sclk_o && !busy_o, "R8", "released after 6 frames", {sclk_o, busy_o}, 0);
    read_frame(24'hC0FFEE, 4, 1'b0);
    chk(word_o == 24'hC0FFEE, "R10", "first frame after sync", word_o, 24'hC0FFEE);
  endtask

  task automatic t_sync_clamp;
    send_sync_req(8'd2);
    for (int k = 0; k < 4; k++) ready_pulse(4, 16);
    chk(sclk_o, "R8", "length below 5 raised to 5", sclk_o, 1);
    ready_pulse(4, 16);
    chk(!sclk_o && !busy_o, "R8", "released after 5 frames", {sclk_o, busy_o}, 0);
  endtask

  task automatic t_sync_timeout;
    send_sync_req(8'd5);
    cyc(245);
    chk(sclk_o, "R9", "held high before 5 frame periods", sclk_o, 1);
    cyc(90);
    chk(!sclk_o && !busy_o, "R9", "released by frame timeout", {sclk_o, busy_o}, 0);
    chk(word_o == last_word, "R6", "word held across sync", word_o, last_word);
    read_frame(24'h0F1E2D, 4, 1'b0);
    chk(word_o == 24'h0F1E2D, "R10", "read after timeout sync", word_o, 24'h0F1E2D);
  endtask

  initial begin
    cyc(3);
    #1;
    t_reset();
    rst_ni = 1'b1;
    cyc(5);
    t_no_pulse();
    t_reads();
    t_sync_during_read();
    t_sync_pulses();
    t_sync_clamp();
    t_sync_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule